// File: doc/BRIEF.md
# Power-Management Event Controller

This block keeps the fixed event flags, enable bits and control fields of an ACPI-style power-management unit. Software reaches them through a plain 16-bit register port with byte-offset addressing. A free-running timer advances on a tick-enable input. Each time a selected timer bit falls, the timer-overflow flag is set. The block also latches flags for power-button presses, RTC alarms and global-release events.

Each flag is paired with its enable bit. The pair drives a level SCI output, a level SMI output, or a wake output. When more than one global enable is set, the SCI enable takes priority over the SMI path. Writing the sleep-go bit sends a one-cycle sleep request to the power sequencer, together with a 3-bit sleep type.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, every register reads 0 and sci, smi, wake and slp_req are low.
- R2: Register layout and read-back:
  - Offset 00h is the flag register: bit 0 timer, bit 5 global, bit 8 button, bit 10 RTC.
  - Offset 02h is the enable register, using the same bit positions.
  - Offset 04h is the control register: bit 0 SCI enable, bit 1 SMI enable, bit 2 timer-SMI enable, bits 12:10 sleep type, bit 13 sleep-go.
  - Offset 08h reads timer bits 15:0 and offset 0Ah reads the upper timer bits.
  - Bits without a function, and offsets without a register, read 0.
- R3: The timer (TMR_W bits, default 24) increments by one on each cycle with tick_en high. The timer flag is set when bit OVF_BIT (default 22) changes from 1 to 0.
- R4: Flags are cleared only by writing 1 to their bit at offset 00h. Writing 0 leaves a flag unchanged.
- R5: With the timer flag, timer enable and SCI enable all set, sci is high.
- R6: With the timer flag, timer enable, timer-SMI enable and SMI enable all set and the SCI enable clear, smi is high. With the SCI enable also set, sci is high and smi is low.
- R7: The button flag with its enable raises sci when the SCI enable is set, or smi when only the SMI enable is set. While sleeping is high, a set button flag raises wake whatever its enable.
- R8: An RTC alarm always sets the RTC flag. The flag raises wake only while sleeping is high and the RTC enable is set. A pwrbtn_ovr pulse clears the RTC enable.
- R9: Sleep-go reads 0. Writing 1 to it gives slp_req high for exactly the cycle after the write, with slp_type equal to the written type. A control write with bit 13 at 0 gives no request.
- R10: The global flag with its enable raises sci regardless of the SCI enable.
- R11: An event and a clear of the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| pwrbtn_evt | input | 1 | Power-button press pulse |
| pwrbtn_ovr | input | 1 | Power-button override pulse |
| rtc_alarm | input | 1 | RTC alarm pulse |
| gbl_rel | input | 1 | Global-release event pulse |
| sleeping | input | 1 | System is in a sleep state |
| sci | output | 1 | SCI level |
| smi | output | 1 | SMI level |
| wake | output | 1 | Wake event level |
| slp_req | output | 1 | One-cycle sleep request |
| slp_type | output | 3 | Requested sleep type |

## Verification
A wrong flag or enable bit appears at the outputs one cycle after the event or write that caused it. It shows as sci, smi or wake at the wrong level, and also in the read-back of offsets 00h or 02h. A timer that miscounts is seen in the read-back of offset 08h. It also changes the cycle in which the timer flag appears, which the bench pins to an exact tick count.

A wrong SCI-over-SMI priority shows the moment the control register changes. A sleep pulse that is too long, missing or carries the wrong type is visible within one cycle of the control write.

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl #(
  parameter int TMR_W   = 24,
  parameter int OVF_BIT = 22,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          pwrbtn_evt,
  input  logic          pwrbtn_ovr,
  input  logic          rtc_alarm,
  input  logic          gbl_rel,
  input  logic          sleeping,
  output logic          sci,
  output logic          smi,
  output logic          wake,
  output logic          slp_req,
  output logic [2:0]    slp_type
);
  localparam logic [AW-1:0] OFS_STS = AW'(0);
  localparam logic [AW-1:0] OFS_EN  = AW'(2);
  localparam logic [AW-1:0] OFS_CTL = AW'(4);
  localparam logic [AW-1:0] OFS_TLO = AW'(8);
  localparam logic [AW-1:0] OFS_THI = AW'(10);
  localparam int B_TMR = 0;
  localparam int B_GBL = 5;
  localparam int B_PB  = 8;
  localparam int B_RTC = 10;

  logic [TMR_W-1:0] tmr, tmr_nxt;
  logic tmr_sts, gbl_sts, pb_sts, rtc_sts;
  logic en_tmr, en_gbl, en_pb, en_rtc;
  logic sci_en, smi_en, tmr_smi_en;
  logic ovf_evt;

  wire wr_sts = reg_wr && (reg_addr == OFS_STS);
  wire wr_en  = reg_wr && (reg_addr == OFS_EN);
  wire wr_ctl = reg_wr && (reg_addr == OFS_CTL);
  wire unused_wbits = ^{reg_wdata[15:14], reg_wdata[9], reg_wdata[7:6], reg_wdata[4:3]};

  assign tmr_nxt = tmr + 1'b1;
  assign ovf_evt = tick_en && tmr[OVF_BIT] && !tmr_nxt[OVF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else if (tick_en) tmr <= tmr_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_sts <= 1'b0;
      gbl_sts <= 1'b0;
      pb_sts  <= 1'b0;
      rtc_sts <= 1'b0;
    end else begin
      tmr_sts <= ovf_evt    | (tmr_sts & ~(wr_sts & reg_wdata[B_TMR]));
      gbl_sts <= gbl_rel    | (gbl_sts & ~(wr_sts & reg_wdata[B_GBL]));
      pb_sts  <= pwrbtn_evt | (pb_sts  & ~(wr_sts & reg_wdata[B_PB]));
      rtc_sts <= rtc_alarm  | (rtc_sts & ~(wr_sts & reg_wdata[B_RTC]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_tmr <= 1'b0;
      en_gbl <= 1'b0;
      en_pb  <= 1'b0;
      en_rtc <= 1'b0;
    end else begin
      if (wr_en) begin
        en_tmr <= reg_wdata[B_TMR];
        en_gbl <= reg_wdata[B_GBL];
        en_pb  <= reg_wdata[B_PB];
      end
      if (pwrbtn_ovr) en_rtc <= 1'b0;
      else if (wr_en) en_rtc <= reg_wdata[B_RTC];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_en     <= 1'b0;
      smi_en     <= 1'b0;
      tmr_smi_en <= 1'b0;
      slp_type   <= 3'd0;
      slp_req    <= 1'b0;
    end else begin
      slp_req <= wr_ctl & reg_wdata[13];
      if (wr_ctl) begin
        sci_en     <= reg_wdata[0];
        smi_en     <= reg_wdata[1];
        tmr_smi_en <= reg_wdata[2];
        slp_type   <= reg_wdata[12:10];
      end
    end
  end

  wire tmr_hit = tmr_sts & en_tmr;
  wire pb_hit  = pb_sts & en_pb;

  assign sci  = (sci_en & (tmr_hit | pb_hit)) | (gbl_sts & en_gbl);
  assign smi  = ~sci_en & smi_en & ((tmr_hit & tmr_smi_en) | pb_hit);
  assign wake = sleeping & (pb_sts | (rtc_sts & en_rtc));

  logic [31:0] tmr_ext;
  assign tmr_ext = 32'(tmr);

  always_comb begin
    reg_rdata = 16'h0000;
    case (reg_addr)
      OFS_STS: begin
        reg_rdata[B_TMR] = tmr_sts;
        reg_rdata[B_GBL] = gbl_sts;
        reg_rdata[B_PB]  = pb_sts;
        reg_rdata[B_RTC] = rtc_sts;
      end
      OFS_EN: begin
        reg_rdata[B_TMR] = en_tmr;
        reg_rdata[B_GBL] = en_gbl;
        reg_rdata[B_PB]  = en_pb;
        reg_rdata[B_RTC] = en_rtc;
      end
      OFS_CTL: reg_rdata = {3'b000, slp_type, 7'd0, tmr_smi_en, smi_en, sci_en};
      OFS_TLO: reg_rdata = tmr_ext[15:0];
      OFS_THI: reg_rdata = tmr_ext[31:16];
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk #(
  parameter int TMR_W = 24,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             pwrbtn_ovr,
  input logic             sci,
  input logic             smi,
  input logic             slp_req,
  input logic             sci_en,
  input logic             en_rtc,
  input logic [TMR_W-1:0] tmr
);
  // R9
  slp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |=> !slp_req);

  // R9
  slp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp_req |-> $past(reg_wr && reg_addr == AW'(4) && reg_wdata[13]));

  // R6
  smi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> !sci_en);

  // R8
  ovr_clears_rtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_ovr |=> !en_rtc);

  // R3
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tmr == $past(tmr) + 1'b1);

  // R3
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tmr));

  // R1
  always @(posedge clk) begin
    if (rst_n && $past(!rst_n)) begin
      reset_outs_chk: assert (!sci && !smi && !slp_req);
    end
  end
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.TMR_W(TMR_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pwrbtn_ovr(pwrbtn_ovr),
  .sci(sci), .smi(smi), .slp_req(slp_req), .sci_en(sci_en),
  .en_rtc(en_rtc), .tmr(tmr)
);

// File: tb/pm_event_ctrl_bench.sv
`timescale 1ns/1ps
module pm_event_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic pwrbtn_evt = 1'b0, pwrbtn_ovr = 1'b0, rtc_alarm = 1'b0, gbl_rel = 1'b0, sleeping = 1'b0;
  logic sci, smi, wake, slp_req;
  logic [2:0] slp_type;

  always #2.5 clk = ~clk;

  pm_event_ctrl #(.TMR_W(24), .OVF_BIT(6), .AW(4)) u_pm_event_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwrbtn_evt(pwrbtn_evt), .pwrbtn_ovr(pwrbtn_ovr), .rtc_alarm(rtc_alarm),
    .gbl_rel(gbl_rel), .sleeping(sleeping), .sci(sci), .smi(smi),
    .wake(wake), .slp_req(slp_req), .slp_type(slp_type)
  );

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  event smp;

  // sel 0: read data, sel 1: {sci,smi,wake}, sel 2: {slp_req,slp_type}
  always @(smp) begin
    item_t it;
    logic [15:0] act;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        0: act = reg_rdata;
        1: act = {13'd0, sci, smi, wake};
        default: act = {12'd0, slp_req, slp_type};
      endcase
      nchk++;
      if (act !== it.exp) begin
        nerr++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int sel, input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> smp;
    #0.2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(posedge clk); #1;
    s = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(0, 4'h0, 16'h0000, "R1 flags after reset");
    chk(0, 4'h2, 16'h0000, "R1 enables after reset");
    chk(0, 4'h4, 16'h0000, "R1 control after reset");
    chk(0, 4'h8, 16'h0000, "R1 timer after reset");
    chk(1, 4'h0, 16'h0000, "R1 sci/smi/wake after reset");
    chk(2, 4'h0, 16'h0000, "R1 sleep outputs after reset");

    wr(4'h2, 16'hFFFF);
    chk(0, 4'h2, 16'h0521, "R2 enable reserved bits read zero");
    wr(4'h2, 16'h0000);
    chk(0, 4'h6, 16'h0000, "R2 unmapped offset reads zero");

    wr(4'h4, 16'h3400);
    chk(2, 4'h0, 16'h000D, "R9 sleep pulse with type 5");
    chk(0, 4'h4, 16'h1400, "R9 sleep-go reads zero");
    @(posedge clk); #1;
    chk(2, 4'h0, 16'h0005, "R9 pulse lasts one cycle");
    wr(4'h4, 16'h1800);
    chk(2, 4'h0, 16'h0006, "R9 no pulse without sleep-go");

    ticks(127);
    chk(0, 4'h8, 16'h007F, "R3 timer count 127");
    chk(0, 4'hA, 16'h0000, "R2 timer upper bits");
    chk(0, 4'h0, 16'h0000, "R3 no flag before bit fall");
    ticks(1);
    chk(0, 4'h8, 16'h0080, "R3 timer count 128");
    chk(0, 4'h0, 16'h0001, "R3 flag on bit fall");

    wr(4'h0, 16'h0000);
    chk(0, 4'h0, 16'h0001, "R4 write zero keeps flag");
    wr(4'h0, 16'h0001);
    chk(0, 4'h0, 16'h0000, "R4 write one clears flag");

    ticks(128);
    chk(0, 4'h0, 16'h0001, "R3 second flag at 256");
    chk(1, 4'h0, 16'h0000, "R5 no sci without enable");
    wr(4'h2, 16'h0001);
    wr(4'h4, 16'h0001);
    chk(1, 4'h0, 16'h0004, "R5 timer raises sci");
    wr(4'h4, 16'h0006);
    chk(1, 4'h0, 16'h0002, "R6 timer raises smi");
    wr(4'h4, 16'h0007);
    chk(1, 4'h0, 16'h0004, "R6 sci enable overrides smi");
    wr(4'h4, 16'h0002);
    chk(1, 4'h0, 16'h0000, "R6 smi needs timer-smi enable");
    wr(4'h0, 16'h0001);

    wr(4'h4, 16'h0001);
    wr(4'h2, 16'h0000);
    pulse(pwrbtn_evt);
    chk(0, 4'h0, 16'h0100, "R7 button flag set");
    chk(1, 4'h0, 16'h0000, "R7 button gated by enable");
    wr(4'h2, 16'h0100);
    chk(1, 4'h0, 16'h0004, "R7 button raises sci");
    wr(4'h4, 16'h0002);
    chk(1, 4'h0, 16'h0002, "R7 button raises smi");
    sleeping = 1'b1;
    wr(4'h2, 16'h0000);
    chk(1, 4'h0, 16'h0001, "R7 button wakes without enable");
    wr(4'h0, 16'h0100);
    chk(1, 4'h0, 16'h0000, "R7 wake drops after clear");

    pulse(rtc_alarm);
    chk(0, 4'h0, 16'h0400, "R8 alarm sets flag without enable");
    chk(1, 4'h0, 16'h0000, "R8 no wake without enable");
    wr(4'h2, 16'h0400);
    chk(1, 4'h0, 16'h0001, "R8 alarm wakes with enable");
    pulse(pwrbtn_ovr);
    chk(0, 4'h2, 16'h0000, "R8 override clears RTC enable");
    chk(1, 4'h0, 16'h0000, "R8 wake drops after override");
    wr(4'h0, 16'h0400);
    sleeping = 1'b0;

    wr(4'h4, 16'h0000);
    pulse(gbl_rel);
    chk(0, 4'h0, 16'h0020, "R10 global flag set");
    chk(1, 4'h0, 16'h0000, "R10 gated by enable");
    wr(4'h2, 16'h0020);
    chk(1, 4'h0, 16'h0004, "R10 sci without sci enable");
    wr(4'h0, 16'h0020);
    chk(1, 4'h0, 16'h0000, "R10 sci drops after clear");

    @(negedge clk);
    rtc_alarm = 1'b1; reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 16'h0400;
    @(posedge clk); #1;
    rtc_alarm = 1'b0; reg_wr = 1'b0;
    chk(0, 4'h0, 16'h0400, "R11 event beats clear");
    wr(4'h0, 16'h0400);
    chk(0, 4'h0, 16'h0000, "R4 flag cleared afterwards");

    done = 1'b1;
    #1;
    finish_run();
  end
endmodule